// File: doc/BRIEF.md
# Per-Block Read-Reference Calibrator

This background engine sits beside a flash controller's read path. It keeps one predicted read-reference code for each erase block and refreshes those predictions during a calibration pass. An external periodic trigger starts each pass, for example once a day. During a pass the engine visits the blocks one after another. For each block it runs a hill-climb that starts from the block's stored code. It probes neighbouring reference codes through a request/acknowledge port, and each probe returns a raw bit-error count. The code that gave the lowest count is written back as the block's new prediction.

Host reads take priority over calibration. While the host-busy input is high, no new probe is launched. A probe that has already been launched is held until it is acknowledged. The block in progress is never abandoned. The prediction table can be read combinationally through a lookup port, so the normal read path can start from a value that is already close to the best one. Each table update is also visible on a write-notification port.

The control of a pass has seven states. IDLE waits for a trigger. LOAD fetches the block's stored code. ISSUE launches the next probe or skips it at a code boundary. WAIT holds until the probe result returns. PICK chooses the search direction. STORE writes the winning code. DONE raises the end-of-pass pulse.

The state transitions are:
- IDLE goes to LOAD on a trigger.
- LOAD goes to ISSUE.
- ISSUE goes to WAIT when it launches a probe.
- ISSUE stays in ISSUE when it skips an upward neighbour at the top code.
- ISSUE goes to PICK when it skips a downward neighbour at the bottom code.
- ISSUE goes to STORE when the next step would leave the code range.
- WAIT goes back to ISSUE after the centre probe, the upward probe, or an improving step.
- WAIT goes to PICK after the downward probe.
- WAIT goes to STORE after a step that does not improve the count.
- PICK goes to ISSUE when a neighbour beats the centre, and to STORE otherwise.
- STORE goes to LOAD when blocks remain, and to DONE after the last block.
- DONE goes to IDLE.

Within a probe, a small port machine moves through three states. It goes from idle to hold when a probe is launched. It goes from hold to request once host-busy is low. It returns to idle on acknowledge.

Top module: `vref_calib`

## Requirements
- R1: After reset every table entry reads CODE_INIT on the lookup port, and busy_o, done_o, tbl_we_o and probe_req_o are low.
- R2: A trigger received while idle starts a pass. The pass performs exactly one table write per block, in ascending block order from 0 to NUM_BLOCKS-1.
- R3: The first probe for each block uses that block's stored code.
- R4: After the centre probe, the engine probes code+1 and then code-1. A neighbour outside [CODE_MIN, CODE_MAX] is skipped. The engine moves to a neighbour whose count is strictly below the centre's count. If both neighbours qualify, it moves downward unless the upward count is strictly lower.
- R5: Once a direction is chosen, the engine keeps stepping one code at a time while each new count is strictly lower than the best so far. At the first step that does not improve, it stops and writes the last accepted code.
- R6: No probe and no table write ever uses a code outside [CODE_MIN, CODE_MAX]. A search that reaches a limit stops there.
- R7: A probe request rises only if host_busy_i was low in the previous cycle. Once raised, the request holds its block and code stable until acknowledged. Stalls change no result.
- R8: done_o pulses for one cycle right after the last block's write, after which busy_o is low. No table write occurs until the next trigger.
- R9: A trigger that arrives while a pass is running is ignored.
- R10: lookup_code_o returns, in the same cycle, the stored code of the block selected by lookup_blk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Periodic pass trigger |
| host_busy_i | input | 1 | Host read in progress; blocks new probes |
| probe_req_o | output | 1 | Probe read request |
| probe_blk_o | output | BLK_W | Block under probe |
| probe_code_o | output | CODE_W | Reference code under probe |
| probe_ack_i | input | 1 | Probe result valid |
| probe_err_i | input | ERR_W | Raw bit-error count of the probe |
| lookup_blk_i | input | BLK_W | Block selected for prediction lookup |
| lookup_code_o | output | CODE_W | Stored prediction of the selected block |
| tbl_we_o | output | 1 | Table write strobe |
| tbl_blk_o | output | BLK_W | Block being written |
| tbl_code_o | output | CODE_W | Code being written |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
The assertions assume three things about the probe responder. It raises probe_ack_i for exactly one cycle, and only while a request is outstanding. It presents the error count in that same cycle. It leaves the request to be removed by the engine. The bench's responder answers each request after a fixed latency with a single-cycle acknowledge and drops it on the following edge. All inputs are changed one nanosecond after a rising edge, so host_busy_i and trig_i are always stable across the edge that samples them. Lookup indices stay below NUM_BLOCKS.

// File: rtl/vref_calib_pkg.sv
package vref_calib_pkg;

    // pass-level sequencing states
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_ISSUE,
        S_WAIT,
        S_PICK,
        S_STORE,
        S_DONE
    } calib_state_e;

    // which probe of the current block is in flight
    typedef enum logic [1:0] {
        PH_CENTER,
        PH_UP,
        PH_DOWN,
        PH_STEP
    } probe_phase_e;

    // probe port handshake states
    typedef enum logic [1:0] {
        P_IDLE,
        P_HOLD,
        P_REQ
    } port_state_e;

endpackage

// File: rtl/vref_pred_table.sv
module vref_pred_table #(
    parameter int NUM_BLOCKS = 16,
    parameter int BLK_W      = 4,
    parameter int CODE_W     = 6,
    parameter int CODE_INIT  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [BLK_W-1:0]  waddr_i,
    input  logic [CODE_W-1:0] wdata_i,
    input  logic [BLK_W-1:0]  raddr_a_i,
    output logic [CODE_W-1:0] rdata_a_o,
    input  logic [BLK_W-1:0]  raddr_b_i,
    output logic [CODE_W-1:0] rdata_b_o
);

    localparam logic [CODE_W-1:0] INIT_VAL = CODE_W'(CODE_INIT);

    logic [CODE_W-1:0] entry_q [NUM_BLOCKS];

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[g] <= INIT_VAL;
            end else if (we_i && (int'(waddr_i) == g)) begin
                entry_q[g] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_a_o = INIT_VAL;
        rdata_b_o = INIT_VAL;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (int'(raddr_a_i) == i) rdata_a_o = entry_q[i];
            if (int'(raddr_b_i) == i) rdata_b_o = entry_q[i];
        end
    end

endmodule

// File: rtl/vref_probe_port.sv
module vref_probe_port
    import vref_calib_pkg::*;
#(
    parameter int BLK_W  = 4,
    parameter int CODE_W = 6,
    parameter int ERR_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              host_busy_i,
    input  logic              ack_i,
    input  logic [ERR_W-1:0]  err_i,
    output logic              req_o,
    output logic [BLK_W-1:0]  blk_o,
    output logic [CODE_W-1:0] code_o,
    output logic              rdy_o,
    output logic [ERR_W-1:0]  err_o
);

    port_state_e       state_q, state_d;
    logic [BLK_W-1:0]  blk_q;
    logic [CODE_W-1:0] code_q;
    logic [ERR_W-1:0]  err_q;
    logic              rdy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= P_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_IDLE:  if (start_i)      state_d = P_HOLD;
            P_HOLD:  if (!host_busy_i) state_d = P_REQ;
            P_REQ:   if (ack_i)        state_d = P_IDLE;
            default:                   state_d = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q  <= '0;
            code_q <= '0;
            err_q  <= '0;
            rdy_q  <= 1'b0;
        end else begin
            rdy_q <= 1'b0;
            if (state_q == P_IDLE && start_i) begin
                blk_q  <= blk_i;
                code_q <= code_i;
            end
            if (state_q == P_REQ && ack_i) begin
                err_q <= err_i;
                rdy_q <= 1'b1;
            end
        end
    end

    always_comb begin
        req_o  = (state_q == P_REQ);
        blk_o  = blk_q;
        code_o = code_q;
        rdy_o  = rdy_q;
        err_o  = err_q;
    end

endmodule

// File: rtl/vref_search_fsm.sv
module vref_search_fsm
    import vref_calib_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int BLK_W      = 4,
    parameter int CODE_W     = 6,
    parameter int ERR_W      = 10,
    parameter int CODE_MIN   = 4,
    parameter int CODE_MAX   = 59
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    output logic [BLK_W-1:0]  blk_o,
    input  logic [CODE_W-1:0] stored_code_i,
    output logic              tbl_we_o,
    output logic [CODE_W-1:0] tbl_code_o,
    output logic              prb_start_o,
    output logic [CODE_W-1:0] prb_code_o,
    input  logic              prb_rdy_i,
    input  logic [ERR_W-1:0]  prb_err_i,
    output logic              busy_o,
    output logic              done_o
);

    localparam logic [CODE_W-1:0] LO   = CODE_W'(CODE_MIN);
    localparam logic [CODE_W-1:0] HI   = CODE_W'(CODE_MAX);
    localparam logic [BLK_W-1:0]  LAST = BLK_W'(NUM_BLOCKS - 1);

    calib_state_e      state_q, state_d;
    probe_phase_e      phase_q;
    logic [BLK_W-1:0]  blk_q;
    logic [CODE_W-1:0] cur_q;
    logic [ERR_W-1:0]  best_q, e_up_q, e_dn_q;
    logic              has_up_q, has_dn_q, dir_up_q;

    logic at_max, at_min, skip, up_ok, dn_ok, go_dn, improve;
    logic [CODE_W-1:0] probe_code;

    always_comb begin
        at_max  = (cur_q >= HI);
        at_min  = (cur_q <= LO);
        up_ok   = has_up_q && (e_up_q < best_q);
        dn_ok   = has_dn_q && (e_dn_q < best_q);
        go_dn   = dn_ok && (!up_ok || (e_dn_q <= e_up_q));
        improve = (prb_err_i < best_q);
        unique case (phase_q)
            PH_CENTER: begin skip = 1'b0;   probe_code = cur_q;          end
            PH_UP:     begin skip = at_max; probe_code = cur_q + 1'b1;   end
            PH_DOWN:   begin skip = at_min; probe_code = cur_q - 1'b1;   end
            PH_STEP: begin
                skip       = dir_up_q ? at_max : at_min;
                probe_code = dir_up_q ? cur_q + 1'b1 : cur_q - 1'b1;
            end
            default:   begin skip = 1'b1;   probe_code = cur_q;          end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (trig_i) state_d = S_LOAD;
            S_LOAD:  state_d = S_ISSUE;
            S_ISSUE: begin
                if (!skip)                  state_d = S_WAIT;
                else if (phase_q == PH_UP)  state_d = S_ISSUE;
                else if (phase_q == PH_DOWN) state_d = S_PICK;
                else                        state_d = S_STORE;
            end
            S_WAIT: begin
                if (prb_rdy_i) begin
                    unique case (phase_q)
                        PH_CENTER, PH_UP: state_d = S_ISSUE;
                        PH_DOWN:          state_d = S_PICK;
                        default:          state_d = improve ? S_ISSUE : S_STORE;
                    endcase
                end
            end
            S_PICK:  state_d = (go_dn || up_ok) ? S_ISSUE : S_STORE;
            S_STORE: state_d = (blk_q == LAST) ? S_DONE : S_LOAD;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= PH_CENTER;
            blk_q    <= '0;
            cur_q    <= LO;
            best_q   <= '0;
            e_up_q   <= '0;
            e_dn_q   <= '0;
            has_up_q <= 1'b0;
            has_dn_q <= 1'b0;
            dir_up_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (trig_i) blk_q <= '0;
                S_LOAD: begin
                    if (stored_code_i < LO)      cur_q <= LO;
                    else if (stored_code_i > HI) cur_q <= HI;
                    else                         cur_q <= stored_code_i;
                    phase_q  <= PH_CENTER;
                    has_up_q <= 1'b0;
                    has_dn_q <= 1'b0;
                end
                S_ISSUE: if (skip && phase_q == PH_UP) phase_q <= PH_DOWN;
                S_WAIT: begin
                    if (prb_rdy_i) begin
                        unique case (phase_q)
                            PH_CENTER: begin
                                best_q  <= prb_err_i;
                                phase_q <= PH_UP;
                            end
                            PH_UP: begin
                                e_up_q   <= prb_err_i;
                                has_up_q <= 1'b1;
                                phase_q  <= PH_DOWN;
                            end
                            PH_DOWN: begin
                                e_dn_q   <= prb_err_i;
                                has_dn_q <= 1'b1;
                            end
                            default: begin
                                if (improve) begin
                                    best_q <= prb_err_i;
                                    cur_q  <= dir_up_q ? cur_q + 1'b1 : cur_q - 1'b1;
                                end
                            end
                        endcase
                    end
                end
                S_PICK: begin
                    if (go_dn) begin
                        cur_q    <= cur_q - 1'b1;
                        best_q   <= e_dn_q;
                        dir_up_q <= 1'b0;
                        phase_q  <= PH_STEP;
                    end else if (up_ok) begin
                        cur_q    <= cur_q + 1'b1;
                        best_q   <= e_up_q;
                        dir_up_q <= 1'b1;
                        phase_q  <= PH_STEP;
                    end
                end
                S_STORE: if (blk_q != LAST) blk_q <= blk_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o      = (state_q != S_IDLE);
        done_o      = (state_q == S_DONE);
        tbl_we_o    = (state_q == S_STORE);
        tbl_code_o  = cur_q;
        blk_o       = blk_q;
        prb_start_o = (state_q == S_ISSUE) && !skip;
        prb_code_o  = probe_code;
    end

endmodule

// File: rtl/vref_calib.sv
module vref_calib #(
    parameter int NUM_BLOCKS = 16,
    parameter int CODE_W     = 6,
    parameter int ERR_W      = 10,
    parameter int CODE_MIN   = 4,
    parameter int CODE_MAX   = 59,
    parameter int CODE_INIT  = 32,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              host_busy_i,
    output logic              probe_req_o,
    output logic [BLK_W-1:0]  probe_blk_o,
    output logic [CODE_W-1:0] probe_code_o,
    input  logic              probe_ack_i,
    input  logic [ERR_W-1:0]  probe_err_i,
    input  logic [BLK_W-1:0]  lookup_blk_i,
    output logic [CODE_W-1:0] lookup_code_o,
    output logic              tbl_we_o,
    output logic [BLK_W-1:0]  tbl_blk_o,
    output logic [CODE_W-1:0] tbl_code_o,
    output logic              busy_o,
    output logic              done_o
);

    logic [BLK_W-1:0]  cur_blk;
    logic [CODE_W-1:0] stored_code;
    logic [CODE_W-1:0] wr_code;
    logic              wr_en;
    logic              prb_start;
    logic [CODE_W-1:0] prb_code;
    logic              prb_rdy;
    logic [ERR_W-1:0]  prb_err;

    vref_pred_table #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W),
        .CODE_W     (CODE_W),
        .CODE_INIT  (CODE_INIT)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr_en),
        .waddr_i   (cur_blk),
        .wdata_i   (wr_code),
        .raddr_a_i (cur_blk),
        .rdata_a_o (stored_code),
        .raddr_b_i (lookup_blk_i),
        .rdata_b_o (lookup_code_o)
    );

    vref_search_fsm #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W),
        .CODE_W     (CODE_W),
        .ERR_W      (ERR_W),
        .CODE_MIN   (CODE_MIN),
        .CODE_MAX   (CODE_MAX)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig_i        (trig_i),
        .blk_o         (cur_blk),
        .stored_code_i (stored_code),
        .tbl_we_o      (wr_en),
        .tbl_code_o    (wr_code),
        .prb_start_o   (prb_start),
        .prb_code_o    (prb_code),
        .prb_rdy_i     (prb_rdy),
        .prb_err_i     (prb_err),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    vref_probe_port #(
        .BLK_W  (BLK_W),
        .CODE_W (CODE_W),
        .ERR_W  (ERR_W)
    ) port_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (prb_start),
        .blk_i       (cur_blk),
        .code_i      (prb_code),
        .host_busy_i (host_busy_i),
        .ack_i       (probe_ack_i),
        .err_i       (probe_err_i),
        .req_o       (probe_req_o),
        .blk_o       (probe_blk_o),
        .code_o      (probe_code_o),
        .rdy_o       (prb_rdy),
        .err_o       (prb_err)
    );

    assign tbl_we_o   = wr_en;
    assign tbl_blk_o  = cur_blk;
    assign tbl_code_o = wr_code;

endmodule

// File: rtl/vref_calib_chk.sv
module vref_calib_chk #(
    parameter int NUM_BLOCKS = 16,
    parameter int CODE_W     = 6,
    parameter int ERR_W      = 10,
    parameter int CODE_MIN   = 4,
    parameter int CODE_MAX   = 59,
    parameter int CODE_INIT  = 32,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_i,
    input logic              host_busy_i,
    input logic              probe_req_o,
    input logic [BLK_W-1:0]  probe_blk_o,
    input logic [CODE_W-1:0] probe_code_o,
    input logic              probe_ack_i,
    input logic [ERR_W-1:0]  probe_err_i,
    input logic [BLK_W-1:0]  lookup_blk_i,
    input logic [CODE_W-1:0] lookup_code_o,
    input logic              tbl_we_o,
    input logic [BLK_W-1:0]  tbl_blk_o,
    input logic [CODE_W-1:0] tbl_code_o,
    input logic              busy_o,
    input logic              done_o
);

    logic             quiet_q;
    logic [BLK_W-1:0] wr_idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q  <= 1'b0;
            wr_idx_q <= '0;
        end else begin
            if (done_o)      quiet_q <= 1'b1;
            else if (trig_i) quiet_q <= 1'b0;
            if (done_o)        wr_idx_q <= '0;
            else if (tbl_we_o) wr_idx_q <= wr_idx_q + 1'b1;
        end
    end

    p_req_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(probe_req_o) |-> !$past(host_busy_i));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req_o && !probe_ack_i) |=>
            (probe_req_o && $stable(probe_code_o) && $stable(probe_blk_o)));

    p_probe_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        probe_req_o |-> (int'(probe_code_o) >= CODE_MIN && int'(probe_code_o) <= CODE_MAX));

    p_write_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we_o |-> (int'(tbl_code_o) >= CODE_MIN && int'(tbl_code_o) <= CODE_MAX));

    p_write_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we_o |-> (busy_o && tbl_blk_o == wr_idx_q));

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q |-> !tbl_we_o);

    p_req_one_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tbl_we_o, probe_req_o}));

endmodule

bind vref_calib vref_calib_chk #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .CODE_W     (CODE_W),
    .ERR_W      (ERR_W),
    .CODE_MIN   (CODE_MIN),
    .CODE_MAX   (CODE_MAX),
    .CODE_INIT  (CODE_INIT)
) chk_i (.*);

// File: tb/vref_calib_tb_top.sv
module vref_calib_tb_top;

    localparam int NB    = 6;
    localparam int CW    = 5;
    localparam int EW    = 8;
    localparam int CMIN  = 2;
    localparam int CMAX  = 29;
    localparam int CINIT = 16;
    localparam int LAT   = 2;
    localparam int BW    = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig = 1'b0;
    logic          host_busy = 1'b0;
    logic          req;
    logic [BW-1:0] pblk;
    logic [CW-1:0] pcode;
    logic          ack = 1'b0;
    logic [EW-1:0] perr = '0;
    logic [BW-1:0] lblk = '0;
    logic [CW-1:0] lcode;
    logic          we;
    logic [BW-1:0] wblk;
    logic [CW-1:0] wcode;
    logic          busy;
    logic          done;

    always #4 clk = ~clk;

    vref_calib #(
        .NUM_BLOCKS (NB), .CODE_W (CW), .ERR_W (EW),
        .CODE_MIN (CMIN), .CODE_MAX (CMAX), .CODE_INIT (CINIT)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .trig_i (trig), .host_busy_i (host_busy),
        .probe_req_o (req), .probe_blk_o (pblk), .probe_code_o (pcode),
        .probe_ack_i (ack), .probe_err_i (perr),
        .lookup_blk_i (lblk), .lookup_code_o (lcode),
        .tbl_we_o (we), .tbl_blk_o (wblk), .tbl_code_o (wcode),
        .busy_o (busy), .done_o (done)
    );

    int n_checks = 0;
    int n_errors = 0;

    // error-count model per block: 0 = V around tgt, 1 = flat, 2 = hump at tgt
    int mode  [NB];
    int tgt   [NB];
    int start [NB];
    int expc  [NB];
    int seq   [NB][3];
    int nseq  [NB];

    int wr_cnt = 0, wr_bad = 0, done_cnt = 0, rise_viol = 0, range_viol = 0;
    bit prev_req = 1'b0, prev_host = 1'b0;
    int lat_cnt = 0;

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int model_err(input int b, input int c);
        int v;
        case (mode[b])
            0: v = 4 * iabs(c - tgt[b]) + 1;
            1: v = 7;
            default: begin
                v = 40 - 4 * iabs(c - tgt[b]);
                if (v < 0) v = 0;
            end
        endcase
        if (v > 255) v = 255;
        return v;
    endfunction

    function automatic int expect_code(input int b, input int s);
        int v;
        case (mode[b])
            0: begin
                v = tgt[b];
                if (v < CMIN) v = CMIN;
                if (v > CMAX) v = CMAX;
            end
            1: v = s;
            default: begin
                v = s - 10;
                if (v < CMIN) v = CMIN;
            end
        endcase
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // probe responder: acknowledges each request after LAT cycles for one cycle
    always @(posedge clk) begin
        #1;
        if (ack) begin
            ack = 1'b0;
        end else if (req) begin
            lat_cnt++;
            if (lat_cnt >= LAT) begin
                lat_cnt = 0;
                perr = EW'(model_err(int'(pblk), int'(pcode)));
                ack = 1'b1;
            end
        end
    end

    // monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (we) begin
                if (int'(wblk) != wr_cnt) wr_bad++;
                wr_cnt++;
            end
            if (done) done_cnt++;
            if (req && !prev_req) begin
                if (prev_host) rise_viol++;
                if (int'(pblk) < NB && nseq[pblk] < 3) begin
                    seq[pblk][nseq[pblk]] = int'(pcode);
                    nseq[pblk]++;
                end
            end
            if (req && (int'(pcode) < CMIN || int'(pcode) > CMAX)) range_viol++;
            prev_req  = req;
            prev_host = host_busy;
        end
    end

    task automatic run_pass(input bit stall, input bit retrig);
        int cyc;
        int d0;
        int w0;
        for (int b = 0; b < NB; b++) begin
            nseq[b] = 0;
            expc[b] = expect_code(b, start[b]);
        end
        wr_cnt = 0; wr_bad = 0; rise_viol = 0; range_viol = 0;
        d0 = done_cnt;
        @(posedge clk); #1 trig = 1'b1;
        @(posedge clk); #1 trig = 1'b0;
        cyc = 0;
        while (done_cnt == d0 && cyc < 20000) begin
            @(posedge clk); #1;
            cyc++;
            host_busy = stall && ((cyc % 17) < 11);
            trig = retrig && (cyc == 40 || cyc == 41);
        end
        host_busy = 1'b0;
        trig = 1'b0;
        chk(cyc < 20000, "R8 watchdog", cyc, 20000);
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy after done", int'(busy), 0);
        chk(done_cnt - d0 == 1, "R8 done pulses", done_cnt - d0, 1);
        w0 = wr_cnt;
        repeat (40) @(posedge clk);
        chk(wr_cnt == w0, "R8 no write after done", wr_cnt - w0, 0);
        chk(wr_cnt == NB, retrig ? "R9 writes with retrigger" : "R2 writes per pass", wr_cnt, NB);
        chk(wr_bad == 0, "R2 write order", wr_bad, 0);
        chk(rise_viol == 0, "R7 request during host read", rise_viol, 0);
        chk(range_viol == 0, "R6 probe code range", range_viol, 0);
        for (int b = 0; b < NB; b++) begin
            int s2;
            lblk = BW'(b);
            #1;
            chk(int'(lcode) == expc[b], "R5 R10 stored result", int'(lcode), expc[b]);
            chk(nseq[b] >= 2 && seq[b][0] == start[b], "R3 first probe", seq[b][0], start[b]);
            s2 = (start[b] < CMAX) ? start[b] + 1 : start[b] - 1;
            chk(seq[b][1] == s2, "R4 second probe", seq[b][1], s2);
            if (start[b] < CMAX && start[b] > CMIN)
                chk(nseq[b] >= 3 && seq[b][2] == start[b] - 1, "R4 third probe", seq[b][2], start[b] - 1);
            start[b] = expc[b];
        end
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            start[b] = CINIT;
            mode[b]  = 0;
            tgt[b]   = CINIT;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !we && !req, "R1 outputs idle", int'({busy, done, we, req}), 0);
        for (int b = 0; b < NB; b++) begin
            lblk = BW'(b);
            #1;
            chk(int'(lcode) == CINIT, "R1 table init", int'(lcode), CINIT);
        end

        // pass 1: V-shaped counts, targets inside and beyond the code range (R6)
        tgt[0] = 0; tgt[1] = 31; tgt[2] = 16; tgt[3] = 10; tgt[4] = 22; tgt[5] = 15;
        run_pass(1'b0, 1'b0);

        // pass 2: host stalls, starts at both limits, one flat block (R4 R7)
        tgt[0] = 5; tgt[1] = 35; tgt[2] = 12; tgt[4] = 19; tgt[5] = 14;
        mode[3] = 1;
        run_pass(1'b1, 1'b0);

        // pass 3: hump centred on start, equal neighbours pick downward (R4 R5)
        for (int b = 0; b < NB; b++) begin
            mode[b] = 2;
            tgt[b]  = start[b];
        end
        run_pass(1'b0, 1'b0);

        // pass 4: trigger repeated mid-pass (R9)
        for (int b = 0; b < NB; b++) begin
            mode[b] = 0;
            tgt[b]  = (b * 5 + 3) % 32;
        end
        run_pass(1'b0, 1'b1);

        // sweep of offsets -4..+4 around the current start
        for (int p = 0; p < 9; p++) begin
            for (int b = 0; b < NB; b++) begin
                mode[b] = 0;
                tgt[b]  = start[b] + ((b + p) % 9) - 4;
            end
            run_pass(p[0], 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule